// File: doc/BRIEF.md
# Timer Interrupt Status Register

This block keeps the sticky record of five timer events: counter overflow, two compare matches and two capture events. Each event sets its own status bit, and the bit holds until software clears it. Software clears a bit by writing a 1 to it. A write of 0 does nothing. The bits always show the raw event history. A separate five-bit enable mask chooses which set bits drive the single combined interrupt line.

The compare bits need extra care. A compare bit sets when its compare-equals-counter condition goes from false to true. If the timer is stopped while that condition still holds, a clear of that bit is refused. The clear works again once the condition goes away, which happens when either the compare value or the counter value moves.

The register is 32 bits wide. Only the low five bits carry state. Reads have one cycle of latency and change nothing. Address decoding is done elsewhere, so the write and read strobes select this register directly.

Top module: `tmr_irq_status`

## Requirements
- R1: Status bit positions: bit 0 overflow, bit 1 compare 0, bit 2 compare 1, bit 3 capture A, bit 4 capture B.
- R2: Bits 31:5 always read as 0, and writing any value to them changes no status bit.
- R3: A status bit sets on its event whether or not the matching enable bit is 1.
- R4: Writing 1 to a status bit that is 1 clears it, except in the case of R7.
- R5: Writing 0 to a status bit leaves it unchanged.
- R6: Writing 1 to a status bit that is 0 leaves it 0 and leaves the interrupt unchanged.
- R7: While the timer is stopped and compare N's equal condition is high, a write-1 to compare N's bit is refused. The clear succeeds once the equal condition goes low.
- R8: After reset all status bits, the read data and the interrupt output are 0.
- R9: If an event and a write-1 to the same bit happen in the same cycle, the bit ends up set.
- R10: The interrupt output equals the OR over the five bits of (status AND enable), taken one clock after that status and enable are present.
- R11: A compare bit sets only on a low-to-high change of its equal condition. An equal condition that stays high does not set the bit again after it has been cleared.
- R12: A read strobe loads the read data with {27'b0, status} one clock later. The read data holds between reads, and a read changes no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ev_ovf_i | input | 1 | Overflow event strobe |
| ev_cap_a_i | input | 1 | Capture A event strobe |
| ev_cap_b_i | input | 1 | Capture B event strobe |
| cmp_eq_i | input | 2 | Level: compare N value equals the counter |
| tmr_run_i | input | 1 | 1 while the timer is counting |
| wr_en_i | input | 1 | Write strobe for this register |
| wdata_i | input | 32 | Write data; a 1 in bits 4:0 requests a clear |
| rd_en_i | input | 1 | Read strobe for this register |
| rdata_o | output | 32 | Read data, valid one clock after rd_en_i |
| irq_en_i | input | 5 | Interrupt enable mask, same bit layout as status |
| irq_o | output | 1 | Combined registered interrupt |

## Verification
An event or a clear sampled at a clock edge changes the status at that same edge. The interrupt follows one edge later. Read data loaded by a strobe appears after the edge that samples the strobe. For that reason, every table step applies its stimulus for one edge and then issues a read for one more edge. Both rdata_o and irq_o are sampled at the falling edge after that second edge, when both results are due together. The interrupt-latency check samples irq_o at the falling edges after the first and the second edge to show the one-cycle delay.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
    localparam int unsigned NUM_SRC  = 5;
    localparam int unsigned NUM_CMP  = 2;
    localparam int unsigned REG_W    = 32;
    // Bit positions of the status word (decoded by software).
    localparam int unsigned IDX_OVF  = 0;
    localparam int unsigned IDX_CMP  = 1;   // compare N sits at IDX_CMP + N
    localparam int unsigned IDX_CAPA = IDX_CMP + NUM_CMP;
    localparam int unsigned IDX_CAPB = IDX_CAPA + 1;

    typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/tmr_cmp_track.sv
module tmr_cmp_track #(
    parameter int unsigned NUM_CMP = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CMP-1:0] cmp_eq_i,
    input  logic               tmr_run_i,
    output logic [NUM_CMP-1:0] set_o,
    output logic [NUM_CMP-1:0] hold_o
);
    typedef struct packed {
        logic [NUM_CMP-1:0] eq_prev;
    } trk_state_t;

    trk_state_t trk_d, trk_q;

    always_comb begin
        trk_d         = trk_q;
        trk_d.eq_prev = cmp_eq_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    for (genvar n = 0; n < NUM_CMP; n++) begin : g_lane
        // A new match is a low-to-high change of the equal condition.
        assign set_o[n]  = cmp_eq_i[n] & ~trk_q.eq_prev[n];
        // A stopped timer with a standing match refuses a clear.
        assign hold_o[n] = cmp_eq_i[n] & ~tmr_run_i;

        // R11: two consecutive rising edges are impossible
        assert_cmp_single_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
            set_o[n] |=> !set_o[n])
            else $error("compare %0d set twice in a row", n);
    end
endmodule

// File: rtl/tmr_irq_stat.sv
module tmr_irq_stat #(
    parameter int unsigned NUM_SRC = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_i,
    input  logic [NUM_SRC-1:0] wclr_i,
    input  logic [NUM_SRC-1:0] hold_i,
    output logic [NUM_SRC-1:0] st_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] st;
    } stat_state_t;

    stat_state_t stat_d, stat_q;
    logic [NUM_SRC-1:0] clr_ok;

    always_comb begin
        stat_d    = stat_q;
        clr_ok    = wclr_i & ~hold_i;
        // A clear only touches a set bit; an event on the same cycle wins.
        stat_d.st = (stat_q.st & ~clr_ok) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    assign st_o = stat_q.st;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
        assert_w1c_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (wclr_i[i] && st_o[i] && !set_i[i] && !hold_i[i]) |=> !st_o[i])
            else $error("bit %0d not cleared", i);

        assert_clear_refused_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (wclr_i[i] && st_o[i] && hold_i[i]) |=> st_o[i])
            else $error("bit %0d cleared while held", i);

        assert_event_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> st_o[i])
            else $error("bit %0d lost an event", i);

        assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (st_o[i] && !wclr_i[i]) |=> st_o[i])
            else $error("bit %0d dropped without a clear", i);

        assert_zero_stays_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (!st_o[i] && !set_i[i]) |=> !st_o[i])
            else $error("bit %0d set without an event", i);
    end
endmodule

// File: rtl/tmr_irq_status.sv
module tmr_irq_status
    import tmr_irq_pkg::*;
#(
    parameter int unsigned DATA_W = REG_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ev_ovf_i,
    input  logic               ev_cap_a_i,
    input  logic               ev_cap_b_i,
    input  logic [NUM_CMP-1:0] cmp_eq_i,
    input  logic               tmr_run_i,
    input  logic               wr_en_i,
    input  logic [DATA_W-1:0]  wdata_i,
    input  logic               rd_en_i,
    output logic [DATA_W-1:0]  rdata_o,
    input  logic [NUM_SRC-1:0] irq_en_i,
    output logic               irq_o
);
    localparam int unsigned PAD_W = DATA_W - NUM_SRC;

    typedef struct packed {
        logic              irq;
        logic [DATA_W-1:0] rdata;
    } top_state_t;

    top_state_t top_d, top_q;

    logic [NUM_CMP-1:0] cmp_set, cmp_hold;
    src_vec_t           set_vec, hold_vec, wclr_vec, st;
    logic               wdata_unused_hi;

    assign wdata_unused_hi = ^wdata_i[DATA_W-1:NUM_SRC];

    tmr_cmp_track #(.NUM_CMP(NUM_CMP)) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmp_eq_i  (cmp_eq_i),
        .tmr_run_i (tmr_run_i),
        .set_o     (cmp_set),
        .hold_o    (cmp_hold)
    );

    always_comb begin
        set_vec                         = '0;
        set_vec[IDX_OVF]                = ev_ovf_i;
        set_vec[IDX_CMP +: NUM_CMP]     = cmp_set;
        set_vec[IDX_CAPA]               = ev_cap_a_i;
        set_vec[IDX_CAPB]               = ev_cap_b_i;
        hold_vec                        = '0;
        hold_vec[IDX_CMP +: NUM_CMP]    = cmp_hold;
        wclr_vec                        = wr_en_i ? wdata_i[NUM_SRC-1:0] : '0;
    end

    tmr_irq_stat #(.NUM_SRC(NUM_SRC)) u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_vec),
        .wclr_i (wclr_vec),
        .hold_i (hold_vec),
        .st_o   (st)
    );

    always_comb begin
        top_d     = top_q;
        top_d.irq = |(st & irq_en_i);
        if (rd_en_i) top_d.rdata = {{PAD_W{1'b0}}, st};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign rdata_o = top_q.rdata;
    assign irq_o   = top_q.irq;

    assert_irq_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((st & irq_en_i) == '0) |=> !irq_o)
        else $error("interrupt high with no enabled status");

    assert_irq_raised_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((st & irq_en_i) != '0) |=> irq_o)
        else $error("interrupt low with enabled status");

    assert_read_value_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_i |=> (rdata_o[NUM_SRC-1:0] == $past(st)))
        else $error("read data does not match status");

    assert_read_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> $stable(rdata_o))
        else $error("read data changed without a read");
endmodule

// File: tb/tmr_irq_status_bench.sv
module tmr_irq_status_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        ev_ovf, ev_cap_a, ev_cap_b;
    logic [1:0]  cmp_eq;
    logic        tmr_run;
    logic        wr_en, rd_en;
    logic [31:0] wdata, rdata;
    logic [4:0]  irq_en;
    logic        irq;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    tmr_irq_status u_tmr_irq_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_ovf_i   (ev_ovf),
        .ev_cap_a_i (ev_cap_a),
        .ev_cap_b_i (ev_cap_b),
        .cmp_eq_i   (cmp_eq),
        .tmr_run_i  (tmr_run),
        .wr_en_i    (wr_en),
        .wdata_i    (wdata),
        .rd_en_i    (rd_en),
        .rdata_o    (rdata),
        .irq_en_i   (irq_en),
        .irq_o      (irq)
    );

    // Vector: ovf capA capB eq[1:0] run wr wdata[4:0] en[4:0] | exp_status[4:0] exp_irq
    // Status layout (R1): b0 ovf, b1 cmp0, b2 cmp1, b3 capA, b4 capB.
    localparam int NVEC = 14;
    localparam logic [22:0] VEC [NVEC] = '{
        23'b1_0_0_00_1_0_00000_00000_00001_0, // R3 ovf sets with enable off
        23'b0_1_0_00_1_0_00000_00001_01001_1, // R1 capA at bit 3
        23'b0_0_0_00_1_1_00001_00001_01000_0, // R4 clear ovf
        23'b0_0_0_00_1_1_00000_01000_01000_1, // R5 write 0
        23'b0_0_0_00_1_1_10100_10100_01000_0, // R6 write 1 to zero bits
        23'b0_0_0_01_1_0_00000_00010_01010_1, // R11 cmp0 rising edge
        23'b0_0_0_01_1_1_00010_00010_01000_0, // R4 clear cmp0 while running
        23'b0_0_0_01_1_0_00000_00010_01000_0, // R11 held match does not re-set
        23'b0_0_0_11_0_0_00000_11111_01100_1, // R11 cmp1 rises, timer stopped
        23'b0_0_0_11_0_1_00100_11111_01100_1, // R7 clear refused
        23'b0_0_0_01_0_1_00100_11111_01000_1, // R7 clear accepted after match ends
        23'b0_0_1_01_0_1_10000_11111_11000_1, // R9 capB event beats clear
        23'b0_0_0_01_0_1_11000_11111_00000_0, // R4 clear two bits
        23'b1_0_0_00_1_1_00001_11111_00001_1  // R9 ovf event beats clear
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock of stimulus, entered and left at a falling edge.
    task automatic step(input logic o, input logic a, input logic b, input logic [1:0] eq,
                        input logic run, input logic w, input logic [31:0] wd,
                        input logic [4:0] en);
        ev_ovf = o; ev_cap_a = a; ev_cap_b = b; cmp_eq = eq; tmr_run = run;
        wr_en = w; wdata = wd; irq_en = en;
        @(negedge clk);
        ev_ovf = 1'b0; ev_cap_a = 1'b0; ev_cap_b = 1'b0; wr_en = 1'b0; wdata = '0;
    endtask

    task automatic do_read();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0;
        ev_ovf = 1'b0; ev_cap_a = 1'b0; ev_cap_b = 1'b0; cmp_eq = '0; tmr_run = 1'b1;
        wr_en = 1'b0; rd_en = 1'b0; wdata = '0; irq_en = '0;
        repeat (3) @(negedge clk);
        check("R8 rdata in reset", rdata, 32'h0);
        check("R8 irq in reset", {31'b0, irq}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        do_read();
        check("R8 status after reset", rdata, 32'h0);

        // R10: interrupt lags the status by one clock.
        step(1'b1, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0, 32'h0, 5'b00001);
        check("R10 irq not yet high", {31'b0, irq}, 32'h0);
        @(negedge clk);
        check("R10 irq high one clock later", {31'b0, irq}, 32'h1);
        step(1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 1'b1, 32'h1, 5'b00001);
        check("R10 irq still high after clear edge", {31'b0, irq}, 32'h1);
        @(negedge clk);
        check("R10 irq low one clock after clear", {31'b0, irq}, 32'h0);
        irq_en = '0;

        for (int k = 0; k < NVEC; k++) begin
            step(VEC[k][22], VEC[k][21], VEC[k][20], VEC[k][19:18], VEC[k][17],
                 VEC[k][16], {27'b0, VEC[k][15:11]}, VEC[k][10:6]);
            do_read();
            check($sformatf("R1 vector %0d status", k), rdata, {27'b0, VEC[k][5:1]});
            check($sformatf("R10 vector %0d irq", k), {31'b0, irq}, {31'b0, VEC[k][0]});
        end

        // R12: read data holds without a read, and reads have no side effect.
        step(1'b0, 1'b1, 1'b0, 2'b00, 1'b1, 1'b0, 32'h0, 5'b00000);
        check("R12 rdata holds without read", rdata, 32'h1);
        do_read();
        check("R12 first read", rdata, 32'h9);
        do_read();
        check("R12 second read unchanged", rdata, 32'h9);

        // R2: writes to reserved bits change nothing; they read as 0.
        step(1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 1'b1, 32'hFFFF_FFE0, 5'b00000);
        do_read();
        check("R2 reserved write ignored", rdata, 32'h9);

        done = 1'b1;
        finish_run();
    end
endmodule